// File: doc/BRIEF.md
# Instruction Fetch Sequencer with Address and Buffer Registers

This block fetches instructions for a small accumulator-style processor. It owns four registers: a program counter (PC), an address register that alone drives the memory address lines, a buffer register that alone drives the memory write-data lines and captures read data, and an instruction register (IR). Each fetch is a fixed sequence of register transfers, and no two of them share a cycle. The PC goes to the address register. A read of that address lands in the buffer. The buffer moves to the IR. When the IR is loaded, the block raises `ir_valid` for one cycle toward the decode stage. It then waits for `exec_done` before it accepts another fetch.

The memory is single-port and synchronous, with one cycle of read latency. The read step therefore spans two cycles: one to issue the read and one to capture the returned word into the buffer. The PC advances during the read-issue cycle. Data writes use the same two interface registers. A requested address and word are loaded into the address and buffer registers first, and a one-cycle write strobe follows. A write request that arrives while a fetch is running is held and served once the sequencer is idle again. While idle, a PC load input can redirect the sequence to a new address.

Top module: `ifs_fetch_seq`

## Requirements
- R1: A synchronous active-high `rst` clears the PC, address register, buffer register and IR to zero. It also drops `ir_valid`, `wr_ack`, `mem_rd` and `mem_wr` and returns the sequencer to idle.
- R2: A fetch begins when `fetch_go` is high on an idle cycle with no PC load and no pending write. In the next cycle `mem_rd` is high for exactly one cycle, with `mem_addr` equal to the PC value at the start of the fetch. `ir_valid` rises in the fourth cycle after the start cycle.
- R3: While `ir_valid` is high, `ir` holds the memory word stored at the fetched address. The word is captured into the buffer one cycle after the read is issued and is copied to the IR in the following cycle, never in the same cycle.
- R4: Each fetch advances the PC by one, modulo 2^AW, in the read-issue cycle. Consecutive fetches therefore read consecutive addresses, and the PC wraps from the highest address to 0.
- R5: `ir_valid` is high for one cycle only. After it, no new fetch starts, even with `fetch_go` held high, until `exec_done` is seen and the sequencer has returned to idle.
- R6: A write request (`wr_req` pulse with `wr_addr`, `wr_data`) served from idle drives `mem_addr`=`wr_addr` and `mem_wdata`=`wr_data`, with `mem_wr` high for one cycle. `wr_ack` is high in the following cycle. It is the third cycle after the request cycle.
- R7: `mem_rd` and `mem_wr` are never high in the same cycle.
- R8: A write request made during a fetch does not reach memory before that fetch completes and `exec_done` returns the sequencer to idle. The fetch returns the old contents of that address, and the write then takes place.
- R9: When `pc_load` is high on an idle cycle, the PC takes `pc_target` on the next edge. This takes priority over a pending write and over `fetch_go`. When `pc_load` is high while a fetch is in progress, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_go | input | 1 | Start a fetch when idle |
| exec_done | input | 1 | Downstream execution finished; release the sequencer |
| pc_load | input | 1 | Overwrite the PC when idle |
| pc_target | input | AW | New PC value for `pc_load` |
| wr_req | input | 1 | Single-cycle data write request |
| wr_addr | input | AW | Write target address |
| wr_data | input | DW | Write data word |
| wr_ack | output | 1 | One-cycle pulse after the write strobe |
| mem_addr | output | AW | Memory address, driven by the address register |
| mem_wdata | output | DW | Memory write data, driven by the buffer register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data, valid one cycle after `mem_rd` |
| pc | output | AW | Current program counter |
| ir | output | DW | Instruction register |
| ir_valid | output | 1 | One-cycle pulse when `ir` has a new instruction |

## Verification
The bench builds the block with AW=4 and DW=8, so the address space is only sixteen words. This lets the bench fetch every location and carry on through the wrap of the PC back to zero. It also rewrites every location through the write path and re-fetches all of them to confirm the new contents. With so few addresses, collisions are cheap to stage: the bench writes the very address being fetched during the fetch, which shows both the deferred write and the old word landing in the IR. It also sends PC loads during fetches and together with `fetch_go`.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_LDIR,
    ST_WAIT,
    ST_WRITE
  } ifs_state_e;
endpackage

// File: rtl/ifs_wrbuf.sv
module ifs_wrbuf #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic          pend_valid,
  output logic [AW-1:0] pend_addr,
  output logic [DW-1:0] pend_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
    end else if (take) begin
      pend_valid <= 1'b0;
    end else if (wr_req && !pend_valid) begin
      pend_valid <= 1'b1;
      pend_addr  <= wr_addr;
      pend_data  <= wr_data;
    end
  end
endmodule

// File: rtl/ifs_ctrl.sv
module ifs_ctrl
  import ifs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fetch_go,
  input  logic exec_done,
  input  logic pc_load,
  input  logic pend_valid,
  output logic ld_pc,
  output logic inc_pc,
  output logic ld_mar_pc,
  output logic ld_mar_wr,
  output logic ld_mbr_mem,
  output logic ld_mbr_wr,
  output logic ld_ir,
  output logic take,
  output logic mem_rd,
  output logic mem_wr,
  output logic ir_valid,
  output logic wr_ack
);
  ifs_state_e state, nxt;

  always_comb begin
    nxt        = state;
    ld_pc      = 1'b0;
    inc_pc     = 1'b0;
    ld_mar_pc  = 1'b0;
    ld_mar_wr  = 1'b0;
    ld_mbr_mem = 1'b0;
    ld_mbr_wr  = 1'b0;
    ld_ir      = 1'b0;
    take       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pc_load) begin
          ld_pc = 1'b1;
        end else if (pend_valid) begin
          ld_mar_wr = 1'b1;
          ld_mbr_wr = 1'b1;
          nxt       = ST_WRITE;
        end else if (fetch_go) begin
          ld_mar_pc = 1'b1;
          nxt       = ST_READ;
        end
      end
      ST_READ: begin
        inc_pc = 1'b1;
        nxt    = ST_CAPT;
      end
      ST_CAPT: begin
        ld_mbr_mem = 1'b1;
        nxt        = ST_LDIR;
      end
      ST_LDIR: begin
        ld_ir = 1'b1;
        nxt   = ST_WAIT;
      end
      ST_WAIT: begin
        if (exec_done) nxt = ST_IDLE;
      end
      ST_WRITE: begin
        take = 1'b1;
        nxt  = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign mem_rd = (state == ST_READ);
  assign mem_wr = (state == ST_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ir_valid <= 1'b0;
      wr_ack   <= 1'b0;
    end else begin
      state    <= nxt;
      ir_valid <= (state == ST_LDIR);
      wr_ack   <= (state == ST_WRITE);
    end
  end
endmodule

// File: rtl/ifs_regs.sv
module ifs_regs #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_pc,
  input  logic          inc_pc,
  input  logic          ld_mar_pc,
  input  logic          ld_mar_wr,
  input  logic          ld_mbr_mem,
  input  logic          ld_mbr_wr,
  input  logic          ld_ir,
  input  logic [AW-1:0] pc_target,
  input  logic [AW-1:0] pend_addr,
  input  logic [DW-1:0] pend_data,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] ir
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
    end else begin
      if (ld_pc)       pc <= pc_target;
      else if (inc_pc) pc <= pc + 1'b1;
      if (ld_mar_pc)      mar <= pc;
      else if (ld_mar_wr) mar <= pend_addr;
      if (ld_mbr_mem)     mbr <= mem_rdata;
      else if (ld_mbr_wr) mbr <= pend_data;
      if (ld_ir) ir <= mbr;
    end
  end
endmodule

// File: rtl/ifs_fetch_seq.sv
module ifs_fetch_seq #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_go,
  input  logic          exec_done,
  input  logic          pc_load,
  input  logic [AW-1:0] pc_target,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ack,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic          ir_valid
);
  logic          pend_valid, take;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;
  logic ld_pc, inc_pc, ld_mar_pc, ld_mar_wr, ld_mbr_mem, ld_mbr_wr, ld_ir;

  ifs_wrbuf #(.AW(AW), .DW(DW)) u_wrbuf (
    .clk(clk), .rst(rst), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .take(take), .pend_valid(pend_valid), .pend_addr(pend_addr), .pend_data(pend_data)
  );

  ifs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .fetch_go(fetch_go), .exec_done(exec_done),
    .pc_load(pc_load), .pend_valid(pend_valid),
    .ld_pc(ld_pc), .inc_pc(inc_pc), .ld_mar_pc(ld_mar_pc), .ld_mar_wr(ld_mar_wr),
    .ld_mbr_mem(ld_mbr_mem), .ld_mbr_wr(ld_mbr_wr), .ld_ir(ld_ir), .take(take),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_valid(ir_valid), .wr_ack(wr_ack)
  );

  ifs_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .ld_pc(ld_pc), .inc_pc(inc_pc), .ld_mar_pc(ld_mar_pc),
    .ld_mar_wr(ld_mar_wr), .ld_mbr_mem(ld_mbr_mem), .ld_mbr_wr(ld_mbr_wr),
    .ld_ir(ld_ir), .pc_target(pc_target), .pend_addr(pend_addr),
    .pend_data(pend_data), .mem_rdata(mem_rdata),
    .pc(pc), .mar(mem_addr), .mbr(mem_wdata), .ir(ir)
  );
endmodule

// File: rtl/ifs_fetch_chk.sv
module ifs_fetch_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [DW-1:0] ir,
  input logic          ir_valid,
  input logic          wr_ack
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (pc == '0 && mem_addr == '0 && mem_wdata == '0 && ir == '0 &&
             !ir_valid && !wr_ack && !mem_rd && !mem_wr));

  a_r2_read_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  a_r3_ir_from_memory: assert property (@(posedge clk) disable iff (rst)
    $rose(ir_valid) |-> ir == $past(mem_rdata, 2));

  a_r4_pc_advance: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> pc == AW'($past(mem_addr) + 1'b1));

  a_r5_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    ir_valid |=> !ir_valid);

  a_r6_ack_after_write: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> wr_ack);

  a_r7_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind ifs_fetch_seq ifs_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir(ir),
  .ir_valid(ir_valid), .wr_ack(wr_ack)
);

// File: tb/tb_ifs_fetch_seq.sv
module tb_ifs_fetch_seq;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fetch_go = 1'b0, exec_done = 1'b0, pc_load = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] pc_target = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ack, mem_rd, mem_wr, ir_valid;
  logic [AW-1:0] mem_addr, pc;
  logic [DW-1:0] mem_wdata, ir;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] mem [NW];
  int exp_mem [NW];
  int n_chk = 0, n_err = 0;
  int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;
  int last_rd_addr = 0, last_wr_addr = 0, last_wr_data = 0;

  always #4 clk = ~clk;

  ifs_fetch_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .fetch_go(fetch_go), .exec_done(exec_done),
    .pc_load(pc_load), .pc_target(pc_target), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .pc(pc), .ir(ir),
    .ir_valid(ir_valid)
  );

  // memory model and port monitors
  always @(posedge clk) begin
    if (mem_rd && mem_wr) both_cnt++;
    if (mem_rd) begin
      rd_cnt++;
      last_rd_addr = int'(mem_addr);
      mem_rdata <= mem[mem_addr];
    end
    if (mem_wr) begin
      wr_cnt++;
      last_wr_addr = int'(mem_addr);
      last_wr_data = int'(mem_wdata);
      mem[mem_addr] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_reset_state();
    chk(pc == '0, "R1", "pc", int'(pc), 0);
    chk(mem_addr == '0 && mem_wdata == '0, "R1", "addr/buffer",
        int'({mem_addr, mem_wdata}), 0);
    chk(ir == '0, "R1", "ir", int'(ir), 0);
    chk(!ir_valid && !wr_ack && !mem_rd && !mem_wr, "R1", "strobes",
        int'({ir_valid, wr_ack, mem_rd, mem_wr}), 0);
  endtask

  task automatic load_pc(input int t);
    @(negedge clk); pc_load = 1'b1; pc_target = AW'(t);
    @(negedge clk); pc_load = 1'b0;
    chk(pc == AW'(t), "R9", "pc after load in idle", int'(pc), t);
  endtask

  // mode 0: plain; 1: pc_load during fetch; 2: write to same address during fetch
  task automatic fetch_one(input int addr, input int mode, input int newval);
    int rd0, wr0, cyc, oldval;
    rd0 = rd_cnt; wr0 = wr_cnt; oldval = exp_mem[addr];
    @(negedge clk); fetch_go = 1'b1;
    @(negedge clk); fetch_go = 1'b0;
    if (mode == 1) begin pc_load = 1'b1; pc_target = AW'(addr + 7); end
    if (mode == 2) begin wr_req = 1'b1; wr_addr = AW'(addr); wr_data = DW'(newval); end
    cyc = 1;
    while (!ir_valid && cyc < 20) begin
      @(negedge clk); pc_load = 1'b0; wr_req = 1'b0; cyc++;
    end
    chk(cyc == 4, "R2", "fetch latency", cyc, 4);
    chk(rd_cnt == rd0 + 1 && last_rd_addr == addr, "R2", "single read at pc",
        last_rd_addr, addr);
    chk(int'(ir) == oldval, "R3", "ir content", int'(ir), oldval);
    chk(int'(pc) == (addr + 1) % NW, "R4", "pc advanced", int'(pc), (addr + 1) % NW);
    if (mode == 1) chk(int'(pc) == (addr + 1) % NW, "R9", "load ignored in fetch",
                       int'(pc), (addr + 1) % NW);
    if (mode == 2) chk(wr_cnt == wr0, "R8", "write held during fetch", wr_cnt, wr0);
    @(negedge clk);
    chk(!ir_valid, "R5", "ir_valid single cycle", int'(ir_valid), 0);
    exec_done = 1'b1;
    @(negedge clk); exec_done = 1'b0;
    if (mode == 2) begin
      cyc = 0;
      while (!wr_ack && cyc < 20) begin @(negedge clk); cyc++; end
      chk(wr_cnt == wr0 + 1 && last_wr_addr == addr && last_wr_data == newval,
          "R8", "deferred write done", last_wr_data, newval);
      exp_mem[addr] = newval;
    end
  endtask

  task automatic write_one(input int a, input int d);
    int wr0, cyc;
    wr0 = wr_cnt;
    @(negedge clk); wr_req = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk); wr_req = 1'b0;
    cyc = 1;
    while (!wr_ack && cyc < 20) begin @(negedge clk); cyc++; end
    chk(cyc == 3, "R6", "write ack latency", cyc, 3);
    chk(wr_cnt == wr0 + 1 && last_wr_addr == a && last_wr_data == d, "R6",
        "write address/data", last_wr_data, d);
    exp_mem[a] = d;
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      exp_mem[i] = (i * 29 + 7) & 8'hFF;
      mem[i] = DW'(exp_mem[i]);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();

    // R2 R3 R4: sweep all addresses and the wrap
    for (int i = 0; i <= NW; i++) fetch_one(i % NW, 0, 0);

    // R5: fetch_go held high while waiting must not start a fetch
    begin
      int rd0;
      @(negedge clk); fetch_go = 1'b1;
      repeat (4) @(negedge clk);
      rd0 = rd_cnt;
      repeat (3) @(negedge clk);
      chk(rd_cnt == rd0, "R5", "no fetch before exec_done", rd_cnt, rd0);
      fetch_go = 1'b0; exec_done = 1'b1;
      @(negedge clk); exec_done = 1'b0;
    end

    // R6: rewrite every location, then re-fetch all
    for (int a = 0; a < NW; a++) write_one(a, (a * 113 + 60) & 8'hFF);
    load_pc(0);
    for (int i = 0; i < NW; i++) fetch_one(i, 0, 0);

    // R9: load during fetch ignored; load in idle redirects
    load_pc(9);
    fetch_one(9, 1, 0);
    load_pc(3);
    fetch_one(3, 0, 0);

    // R8: write to the address being fetched
    load_pc(12);
    fetch_one(12, 2, 8'hA5);
    load_pc(12);
    fetch_one(12, 0, 0);

    // R9: pc_load wins over fetch_go
    begin
      int rd0;
      rd0 = rd_cnt;
      @(negedge clk); pc_load = 1'b1; fetch_go = 1'b1; pc_target = AW'(5);
      @(negedge clk); pc_load = 1'b0; fetch_go = 1'b0;
      repeat (3) @(negedge clk);
      chk(rd_cnt == rd0 && pc == AW'(5), "R9", "load beats fetch_go", int'(pc), 5);
    end

    chk(both_cnt == 0, "R7", "read and write together", both_cnt, 0);

    // R1: reset in the middle of operation
    fetch_one(5, 0, 0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check_reset_state();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule